// File: doc/BRIEF.md
# Two-Stage Streaming Radix-2 Transform Front End with Half-Size Twiddle Table

This block carries out the first two radix-2 decimation-in-frequency passes of an N-point transform on a stream of complex samples, one sample per clock when `in_valid` is high. Each pass is a single-path delay-feedback stage. It has a delay memory and an add/subtract butterfly, and the stage writes its differences back into that memory so they leave later. The result is the stream of N/4 partial products that a downstream N/4-point transform consumes, already multiplied by its twiddle factors.

The sample index is split as n = (N/2)n1 + (N/4)n2 + n3 and the result index as k = k1 + 2k2 + 4k3. The second stage rotates some of its inputs before they reach its butterfly. Samples with n2 = 1 in the k1 = 1 half take a -j turn, done by a swap and a negate. Samples with odd n3 in that half are also turned by W_N^1 in a shift-add constant rotator. After these rotations, every exponent left for the general multiplier that follows is even. The coefficient table therefore holds only N/2 entries.

Each stage is controlled by a three-state phase machine that steps once every `DEPTH` accepted samples. The states are `PH_PRIME` (first fill after reset, nothing emitted), `PH_COMBINE` (emit the sum, store the difference) and `PH_LOAD` (emit a stored difference, store the new sample). The transitions are PRIME→COMBINE, COMBINE→LOAD and LOAD→COMBINE. Once a stage has left PRIME it never returns to it.

Top module: `fft_stage_pair`

## Requirements
- R1: While reset is asserted, and after it until the first result, `out_valid` is low and `out_re`/`out_im` are zero.
- R2: Every result appears exactly three clocks after the accepted input that completes it. After K accepted inputs, K − 3N/4 results have been produced, because the two delay memories of N/2 and N/4 entries must fill first.
- R3: A cycle with `in_valid` low advances no state and produces no result, and it does not change any later result.
- R4: Within each group of N results, result number u carries k1 = u / (N/2), k2 = (u / (N/4)) mod 2 and n3 = u mod (N/4).
- R5: The first stage pairs x[j] with x[j+N/2] through an N/2-entry memory. It emits the sum for k1 = 0 and the difference for k1 = 1, with no twiddle.
- R6: In the k1 = 1 half, a second-stage input with n2 = 1 is multiplied by −j as (a, b) → (b, −a), without a multiplier.
- R7: In the k1 = 1 half, every second-stage input with odd n3 is first multiplied by W_N^1 = cos(2π/N) − j·sin(2π/N). The constants are in canonical signed-digit form with TW−1 fraction bits and are applied by shifts and adds. The second stage uses an N/4-entry memory and emits the sum for k2 = 0 and the difference for k2 = 1.
- R8: The general twiddle exponent is e = n3·(k1+2k2) for even n3 and e = (n3−1)·(k1+2k2) + 2k2 for odd n3, taken mod N. It is always even, and it addresses a table of N/2 entries at e/2.
- R9: Each result equals W_N^{n3(k1+2k2)} · Σ over n1, n2 of x[n]·(−1)^{n1k1}·(−j)^{n2k1}·(−1)^{n2k2}, within 5 LSB, when every input component lies in ±(2^(DW−3) − 1).
- R10: Table coefficients are TW-bit two's complement with TW−1 fraction bits, and +1.0 saturates to the largest code. Each product is rounded half-up by an arithmetic shift, and results are DW+2 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_re | input | DW | Input real part, two's complement |
| in_im | input | DW | Input imaginary part, two's complement |
| out_valid | output | 1 | Result strobe |
| out_re | output | DW+2 | Result real part |
| out_im | output | DW+2 | Result imaginary part |

## Verification
The bench builds the block with N = 16, DW = 12 and TW = 12. The delay memories are then 8 and 4 entries deep, so many whole frames fit into a short run. At this size, all sixteen impulse positions can be applied, and every (k1, k2, n3) cell in every frame is compared against a real-valued reference. This covers both sides of the −j swap, the odd-n3 constant rotation and every even table address. Full-scale corner frames and frames broken up by idle cycles check the headroom and the rule that idle cycles have no effect.

// File: rtl/fftpair_pkg.sv
package fftpair_pkg;

    typedef enum logic [1:0] {
        PH_PRIME   = 2'd0,
        PH_COMBINE = 2'd1,
        PH_LOAD    = 2'd2
    } sdf_phase_t;

    localparam real TWO_PI = 6.283185307179586;

    // Round x * 2^fb to nearest; optionally clamp to a (fb+1)-bit signed range.
    function automatic int quant(input real x, input int fb, input bit sat);
        real s;
        int  q;
        s = x * (2.0 ** fb);
        q = (s >= 0.0) ? $rtoi(s + 0.5) : $rtoi(s - 0.5);
        if (sat) begin
            if (q > (1 << fb) - 1) q = (1 << fb) - 1;
            if (q < -(1 << fb))    q = -(1 << fb);
        end
        return q;
    endfunction

    // Canonical signed-digit masks of a non-negative value: {minus digits, plus digits}.
    function automatic logic [63:0] csd_masks(input longint value);
        logic [31:0] plus_d;
        logic [31:0] minus_d;
        longint      v;
        v       = value;
        plus_d  = '0;
        minus_d = '0;
        for (int i = 0; i < 32; i++) begin
            if (v % 2 != 0) begin
                if (v % 4 == 1) begin
                    plus_d[i] = 1'b1;
                    v = v - 1;
                end else begin
                    minus_d[i] = 1'b1;
                    v = v + 1;
                end
            end
            v = v / 2;
        end
        return {minus_d, plus_d};
    endfunction

endpackage

// File: rtl/fftpair_sdf_stage.sv
module fftpair_sdf_stage
    import fftpair_pkg::*;
#(
    parameter int IW    = 12,
    parameter int DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic signed [IW-1:0] in_re,
    input  logic signed [IW-1:0] in_im,
    output logic                 out_vld,
    output logic signed [IW:0]   out_re,
    output logic signed [IW:0]   out_im
);
    localparam int OW = IW + 1;
    localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    sdf_phase_t st, st_nxt;
    logic [CW-1:0] cnt;
    logic          last;

    logic signed [OW-1:0] mem_re [DEPTH];
    logic signed [OW-1:0] mem_im [DEPTH];

    logic signed [OW-1:0] fb_re, fb_im, ext_re, ext_im;
    logic signed [OW-1:0] wr_re, wr_im, res_re, res_im;
    logic                 emit;

    assign last   = (cnt == CW'(DEPTH - 1));
    assign fb_re  = mem_re[cnt];
    assign fb_im  = mem_im[cnt];
    assign ext_re = OW'(in_re);
    assign ext_im = OW'(in_im);

    // next phase
    always_comb begin
        unique case (st)
            PH_PRIME:   st_nxt = PH_COMBINE;
            PH_COMBINE: st_nxt = PH_LOAD;
            PH_LOAD:    st_nxt = PH_COMBINE;
            default:    st_nxt = PH_PRIME;
        endcase
    end

    // phase register and position counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= PH_PRIME;
            cnt <= '0;
        end else if (in_vld) begin
            cnt <= last ? '0 : cnt + 1'b1;
            if (last) st <= st_nxt;
        end
    end

    // per-phase datapath selection
    always_comb begin
        wr_re  = ext_re;
        wr_im  = ext_im;
        res_re = fb_re;
        res_im = fb_im;
        emit   = 1'b0;
        unique case (st)
            PH_PRIME: begin
                emit = 1'b0;
            end
            PH_COMBINE: begin
                wr_re  = fb_re - ext_re;
                wr_im  = fb_im - ext_im;
                res_re = fb_re + ext_re;
                res_im = fb_im + ext_im;
                emit   = 1'b1;
            end
            PH_LOAD: begin
                emit = 1'b1;
            end
            default: begin
                emit = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (in_vld) begin
            mem_re[cnt] <= wr_re;
            mem_im[cnt] <= wr_im;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_re  <= '0;
            out_im  <= '0;
        end else begin
            out_vld <= in_vld & emit;
            if (in_vld & emit) begin
                out_re <= res_re;
                out_im <= res_im;
            end
        end
    end

    // R2: a result only follows an accepted sample
    a_r2_out_from_in: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_vld));

    // R2: a sample accepted while combining always yields a result
    a_r2_combine_emits: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && st == PH_COMBINE) |=> out_vld);

    // R2: the priming phase happens once after reset
    a_r2_prime_once: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PH_PRIME) |=> (st != PH_PRIME));

    // R3: idle cycles hold position and emit nothing
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(cnt) && !out_vld));

endmodule

// File: rtl/fftpair_csd_mult.sv
module fftpair_csd_mult
    import fftpair_pkg::*;
#(
    parameter int     AW   = 13,
    parameter int     ND   = 13,
    parameter longint COEF = 1
) (
    input  logic signed [AW+ND-1:0] a_ext,
    output logic signed [AW+ND-1:0] prod
);
    localparam int          PW = AW + ND;
    localparam logic [63:0] M  = csd_masks(COEF);

    logic signed [PW-1:0] term [ND];

    generate
        for (genvar i = 0; i < ND; i++) begin : g_digit
            if (M[i]) begin : g_plus
                assign term[i] = a_ext <<< i;
            end else if (M[32+i]) begin : g_minus
                assign term[i] = -(a_ext <<< i);
            end else begin : g_zero
                assign term[i] = '0;
            end
        end
    endgenerate

    always_comb begin
        prod = '0;
        for (int i = 0; i < ND; i++) prod = prod + term[i];
    end

endmodule

// File: rtl/fftpair_const_rot.sv
module fftpair_const_rot
    import fftpair_pkg::*;
#(
    parameter int N_PTS = 2048,
    parameter int W     = 13,
    parameter int FB    = 11
) (
    input  logic signed [W-1:0] in_re,
    input  logic signed [W-1:0] in_im,
    output logic signed [W-1:0] out_re,
    output logic signed [W-1:0] out_im
);
    localparam int     ND  = FB + 2;
    localparam int     PW  = W + ND;
    localparam longint CK  = longint'(quant($cos(TWO_PI / real'(N_PTS)), FB, 1'b0));
    localparam longint SK  = longint'(quant($sin(TWO_PI / real'(N_PTS)), FB, 1'b0));
    localparam logic signed [PW:0] RND = (PW+1)'(1) <<< (FB - 1);

    logic signed [PW-1:0] ax, bx, ac, bs, bc, as_;
    logic signed [PW:0]   sre, sim;

    assign ax = PW'(in_re);
    assign bx = PW'(in_im);

    fftpair_csd_mult #(.AW(W), .ND(ND), .COEF(CK)) u_ac (.a_ext(ax), .prod(ac));
    fftpair_csd_mult #(.AW(W), .ND(ND), .COEF(SK)) u_bs (.a_ext(bx), .prod(bs));
    fftpair_csd_mult #(.AW(W), .ND(ND), .COEF(CK)) u_bc (.a_ext(bx), .prod(bc));
    fftpair_csd_mult #(.AW(W), .ND(ND), .COEF(SK)) u_as (.a_ext(ax), .prod(as_));

    // (a + jb)(c - js) = (ac + bs) + j(bc - as)
    assign sre    = (PW+1)'(ac) + (PW+1)'(bs) + RND;
    assign sim    = (PW+1)'(bc) - (PW+1)'(as_) + RND;
    assign out_re = W'(sre >>> FB);
    assign out_im = W'(sim >>> FB);

endmodule

// File: rtl/fftpair_twiddle.sv
module fftpair_twiddle
    import fftpair_pkg::*;
#(
    parameter int N_PTS = 2048,
    parameter int W     = 14,
    parameter int TW    = 12
) (
    input  logic [$clog2(N_PTS)-2:0] idx,
    input  logic signed [W-1:0]      h_re,
    input  logic signed [W-1:0]      h_im,
    output logic signed [W-1:0]      y_re,
    output logic signed [W-1:0]      y_im
);
    localparam int HALF = N_PTS / 2;
    localparam int FB   = TW - 1;
    localparam int PW   = W + TW + 1;
    localparam logic signed [PW-1:0] RND = PW'(1) <<< (FB - 1);

    logic signed [TW-1:0] rom_c [HALF];
    logic signed [TW-1:0] rom_s [HALF];

    generate
        for (genvar g = 0; g < HALF; g++) begin : g_rom
            localparam real ANG = TWO_PI * real'(2 * g) / real'(N_PTS);
            localparam int  QC  = quant($cos(ANG), FB, 1'b1);
            localparam int  QS  = quant(-$sin(ANG), FB, 1'b1);
            assign rom_c[g] = TW'(QC);
            assign rom_s[g] = TW'(QS);
        end
    endgenerate

    logic signed [TW-1:0] cr, ci;
    logic signed [PW-1:0] pr, pi;

    assign cr = rom_c[idx];
    assign ci = rom_s[idx];

    assign pr   = PW'(h_re) * PW'(cr) - PW'(h_im) * PW'(ci) + RND;
    assign pi   = PW'(h_re) * PW'(ci) + PW'(h_im) * PW'(cr) + RND;
    assign y_re = W'(pr >>> FB);
    assign y_im = W'(pi >>> FB);

endmodule

// File: rtl/fft_stage_pair.sv
module fft_stage_pair
    import fftpair_pkg::*;
#(
    parameter int N_PTS = 2048,
    parameter int DW    = 12,
    parameter int TW    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 out_valid,
    output logic signed [DW+1:0] out_re,
    output logic signed [DW+1:0] out_im
);
    localparam int LOGN = $clog2(N_PTS);
    localparam int QW   = LOGN - 2;
    localparam int W1   = DW + 1;
    localparam int W2   = DW + 2;

    // ---------------- first stage: N/2 feedback ----------------
    logic                 s1_vld;
    logic signed [W1-1:0] s1_re, s1_im;

    fftpair_sdf_stage #(.IW(DW), .DEPTH(N_PTS / 2)) u_st1 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_valid), .in_re(in_re), .in_im(in_im),
        .out_vld(s1_vld), .out_re(s1_re), .out_im(s1_im)
    );

    logic [LOGN-1:0] pos1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pos1 <= '0;
        else if (s1_vld) pos1 <= pos1 + 1'b1;
    end

    // ---------------- input-side rotations ----------------
    logic                 k1a, n2a, odd_a;
    logic signed [W1-1:0] cr_re, cr_im, a_re, a_im, r_re, r_im;

    assign k1a   = pos1[LOGN-1];
    assign n2a   = pos1[LOGN-2];
    assign odd_a = pos1[0];

    fftpair_const_rot #(.N_PTS(N_PTS), .W(W1), .FB(TW - 1)) u_rot (
        .in_re(s1_re), .in_im(s1_im), .out_re(cr_re), .out_im(cr_im)
    );

    always_comb begin
        a_re = s1_re;
        a_im = s1_im;
        if (k1a && odd_a) begin
            a_re = cr_re;
            a_im = cr_im;
        end
        r_re = a_re;
        r_im = a_im;
        if (k1a && n2a) begin
            r_re = a_im;
            r_im = -a_re;
        end
    end

    // ---------------- second stage: N/4 feedback ----------------
    logic                 s2_vld;
    logic signed [W2-1:0] s2_re, s2_im;

    fftpair_sdf_stage #(.IW(W1), .DEPTH(N_PTS / 4)) u_st2 (
        .clk(clk), .rst_n(rst_n), .in_vld(s1_vld), .in_re(r_re), .in_im(r_im),
        .out_vld(s2_vld), .out_re(s2_re), .out_im(s2_im)
    );

    logic [LOGN-1:0] pos2;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pos2 <= '0;
        else if (s2_vld) pos2 <= pos2 + 1'b1;
    end

    // ---------------- even-exponent twiddle ----------------
    logic            k1b, k2b;
    logic [QW-1:0]   n3b;
    logic [LOGN-1:0] fac, n3_ev, expo;

    assign k1b   = pos2[LOGN-1];
    assign k2b   = pos2[LOGN-2];
    assign n3b   = pos2[QW-1:0];
    assign fac   = LOGN'({k2b, k1b});
    assign n3_ev = LOGN'(n3b) & ~(LOGN'(1));
    assign expo  = n3_ev * fac + (n3b[0] ? LOGN'({k2b, 1'b0}) : '0);

    logic signed [W2-1:0] y_re, y_im;

    fftpair_twiddle #(.N_PTS(N_PTS), .W(W2), .TW(TW)) u_tw (
        .idx(expo[LOGN-1:1]), .h_re(s2_re), .h_im(s2_im), .y_re(y_re), .y_im(y_im)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= s2_vld;
            if (s2_vld) begin
                out_re <= y_re;
                out_im <= y_im;
            end
        end
    end

    // R8: the general multiplier is only ever addressed with an even exponent
    a_r8_even_exponent: assert property (@(posedge clk) disable iff (!rst_n)
        s2_vld |-> !expo[0]);

    // R2: a result follows a second-stage sample by one clock
    a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(s2_vld));

endmodule

// File: tb/tb_fft_stage_pair.sv
module tb_fft_stage_pair;
    localparam int NP  = 16;
    localparam int DW  = 12;
    localparam int TW  = 12;
    localparam int OW  = DW + 2;
    localparam int NF  = 23;
    localparam int TOT = (NF + 1) * NP;
    localparam int TOL = 5;
    localparam real PI2 = 6.283185307179586;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_re = '0;
    logic signed [DW-1:0] in_im = '0;
    logic                 out_valid;
    logic signed [OW-1:0] out_re, out_im;

    always #5 clk = ~clk;

    fft_stage_pair #(.N_PTS(NP), .DW(DW), .TW(TW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    int fr [TOT];
    int fi [TOT];
    int cap_re [TOT];
    int cap_im [TOT];
    int ncap = 0;
    int total = 0;
    int bad = 0;
    int late_bad = 0;
    bit vh0 = 0, vh1 = 0, vh2 = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // output capture and latency bookkeeping, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && !vh2) late_bad++;
            if (out_valid && ncap < TOT) begin
                cap_re[ncap] = int'(out_re);
                cap_im[ncap] = int'(out_im);
                ncap++;
            end
            vh2 = vh1;
            vh1 = vh0;
            vh0 = in_valid;
        end
    end

    function automatic void build_frames();
        logic [31:0] seed;
        seed = 32'h1234_5678;
        for (int f = 0; f <= NF; f++) begin
            for (int n = 0; n < NP; n++) begin
                int r, i;
                r = 0;
                i = 0;
                if (f == 0) begin
                    r = 300; i = -200;
                end else if (f <= 16) begin
                    if (n == f - 1) begin r = 400; i = -150; end
                end else if (f == 17) begin
                    r = (n % 2 != 0) ? -511 : 511;
                    i = (n % 3 == 0) ? 511 : -511;
                end else if (f == 18) begin
                    r = $rtoi(500.0 * $cos(PI2 * 3.0 * real'(n) / real'(NP)));
                    i = $rtoi(500.0 * $sin(PI2 * 3.0 * real'(n) / real'(NP)));
                end else if (f <= 21) begin
                    seed = seed * 32'd1103515245 + 32'd12345;
                    r = int'((seed >> 16) % 32'd1023) - 511;
                    seed = seed * 32'd1103515245 + 32'd12345;
                    i = int'((seed >> 16) % 32'd1023) - 511;
                end else if (f == 22) begin
                    r = -511; i = -511;
                end
                fr[f*NP + n] = r;
                fi[f*NP + n] = i;
            end
        end
    endfunction

    // reference: twiddled two-pass partial product (R9)
    task automatic ref_val(input int f, input int u, output real er, output real ei);
        int  k1, k2, n3;
        real sr, si, c, s, th;
        k1 = u / (NP / 2);
        k2 = (u / (NP / 4)) % 2;
        n3 = u % (NP / 4);
        sr = 0.0;
        si = 0.0;
        for (int n1 = 0; n1 < 2; n1++) begin
            for (int n2 = 0; n2 < 2; n2++) begin
                real a, b, t;
                a = real'(fr[f*NP + (NP/2)*n1 + (NP/4)*n2 + n3]);
                b = real'(fi[f*NP + (NP/2)*n1 + (NP/4)*n2 + n3]);
                if (n1 == 1 && k1 == 1) begin a = -a; b = -b; end
                if (n2 == 1 && k1 == 1) begin t = a; a = b; b = -t; end
                if (n2 == 1 && k2 == 1) begin a = -a; b = -b; end
                sr += a;
                si += b;
            end
        end
        th = PI2 * real'(n3 * (k1 + 2 * k2)) / real'(NP);
        c  = $cos(th);
        s  = $sin(th);
        er = sr * c + si * s;
        ei = si * c - sr * s;
    endtask

    function automatic int rnd(input real x);
        return (x >= 0.0) ? $rtoi(x + 0.5) : $rtoi(x - 0.5);
    endfunction

    function automatic int absi(input int x);
        return (x < 0) ? -x : x;
    endfunction

    initial begin
        build_frames();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        check(out_re == '0 && out_im == '0, "R1 data in reset", int'(out_re), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        check(out_re == '0 && out_im == '0, "R1 data after reset", int'(out_im), 0);
        @(posedge clk);
        #1;
        for (int f = 0; f <= NF; f++) begin
            for (int n = 0; n < NP; n++) begin
                if (f % 4 == 2 && n % 5 == 3) begin
                    in_valid = 1'b0;
                    in_re    = DW'(999);
                    in_im    = DW'(-999);
                    repeat (2) begin
                        @(posedge clk);
                        #1;
                    end
                end
                in_valid = 1'b1;
                in_re    = DW'(fr[f*NP + n]);
                in_im    = DW'(fi[f*NP + n]);
                @(posedge clk);
                #1;
            end
        end
        in_valid = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);

        check(ncap == TOT - 3 * NP / 4, "R2 result count", ncap, TOT - 3 * NP / 4);
        check(late_bad == 0, "R2 R3 result without input three clocks before", late_bad, 0);

        for (int idx = 0; idx < NF * NP; idx++) begin
            int    f, u, k1, k2, n3, xr, xi;
            real   er, ei;
            string tag;
            f  = idx / NP;
            u  = idx % NP;
            k1 = u / (NP / 2);
            k2 = (u / (NP / 4)) % 2;
            n3 = u % (NP / 4);
            ref_val(f, u, er, ei);
            xr = rnd(er);
            xi = rnd(ei);
            tag = (k1 == 0) ? "R4 R9 R10 R5" : ((n3 % 2 != 0) ? "R4 R9 R10 R7" : "R4 R9 R10 R6");
            if (n3 * (k1 + 2 * k2) > 0) tag = {tag, " R8"};
            if (f % 4 == 2) tag = {tag, " R3"};
            tag = $sformatf("%s frame=%0d u=%0d", tag, f, u);
            check(absi(cap_re[idx] - xr) <= TOL, {tag, " re"}, cap_re[idx], xr);
            check(absi(cap_im[idx] - xi) <= TOL, {tag, " im"}, cap_im[idx], xi);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule